// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a 16-byte data memory that answers on a two-wire serial bus made of a clock line (SCL) and an open-drain data line (SDA). A system clock that runs much faster than SCL samples both lines. The block detects bus start and stop conditions and checks a control byte against a fixed device code. It then either stores one byte at a word address or returns bytes from an internal address counter. Each line passes through a short synchroniser. The data line is driven only by pulling it low, through `sda_pull_o`. The external wiring combines that pull with the master's drive.

A write is a control byte with the read/write bit at 0, then a word address, then a data byte, closed by a stop. That stop stores the byte and starts an internal write period of `WRITE_CYCLES` system clocks. During that period the block gives no acknowledge, so a master polling it sees a NACK until the write is done. A read is a control byte with the read/write bit at 1. It returns the byte at the address counter, most significant bit first. The counter then steps on, wrapping modulo 16, and further bytes follow while the master keeps acknowledging.

The controller has eight states:

| State | Role |
|---|---|
| ST_IDLE | Bus free. |
| ST_CTRL | Shifting in the control byte. |
| ST_ADDR | Shifting in the word address. |
| ST_DATA | Shifting in data. |
| ST_ACK | The ninth clock of a received byte. |
| ST_RD_SEND | Shifting a byte out. |
| ST_RD_ACK | The master's ninth clock after a byte sent. |
| ST_WAIT | Ignoring the bus until the next start or stop. |

The transitions are these:

- Any state goes to ST_CTRL on START and to ST_IDLE on STOP.
- ST_CTRL, ST_ADDR and ST_DATA go to ST_ACK on the eighth SCL rise.
- ST_ACK moves on at the falling edge that ends the ninth clock. It goes to the stored follow-on state (ST_ADDR, ST_DATA or ST_RD_SEND) when it acknowledged, and to ST_WAIT when it did not.
- ST_RD_SEND goes to ST_RD_ACK after the eighth bit's falling edge.
- ST_RD_ACK goes back to ST_RD_SEND when the master acknowledged, and to ST_WAIT when it did not.

Top module: `twm_eeprom_slave`

## Requirements
- R1: After reset SDA is released, every stored byte is 0x00, the address counter is 0 and no write period is running.
- R2: A START (SDA falling while SCL is high) restarts control-byte decoding from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R3: The control byte is accepted only when its bits 7:4 equal 1010. Bits 3:1 are ignored. Bit 0 selects read (1) or write (0). A byte that does not match is not acknowledged, and the bus is ignored until the next START or STOP.
- R4: When a received byte is acknowledged, SDA is pulled low from the falling SCL edge after the eighth bit until the falling edge that ends the ninth clock.
- R5: The byte after a write control byte is the word address. Bits 3:0 load the address counter and bits 7:4 are ignored.
- R6: A STOP that follows a complete data byte stores that byte and starts a write period of WRITE_CYCLES clocks. During that period SDA is never pulled, so control bytes get no acknowledge.
- R7: After a byte write the address counter still points at the location just written.
- R8: A STOP that arrives before a complete data byte aborts the command. Nothing is stored and no write period starts.
- R9: When more than one data byte is sent, each new data bit after a full byte discards the loaded byte, and the last complete byte is the one stored. A STOP in the middle of such a following byte aborts the write.
- R10: A read returns the byte at the address counter, MSB first, and the counter then increments modulo 16. A master acknowledge after a byte requests the next byte. A master NACK ends the read and releases SDA.
- R11: The block changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit); 0 releases it |

## Verification
The assertions assume the master changes SDA only while SCL is low, except to form START and STOP. They also assume each SCL phase lasts several system clocks longer than the synchroniser delay, so that every edge and condition is seen exactly once. The stimulus uses a 4-clock quarter period, with SDA moved only in the middle of the low phase. Aborts, mid-byte restarts and extra data bytes are all built from complete SCL phases, so that no line changes during an illegal phase.

// File: rtl/twm_pkg.sv
package twm_pkg;
    localparam int TWM_BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_RD_SEND,
        ST_RD_ACK,
        ST_WAIT
    } twm_state_e;
endpackage

// File: rtl/twm_line_mon.sv
module twm_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // idle bus is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
            scl_prev <= scl_pipe[MSB];
            sda_prev <= sda_pipe[MSB];
        end
    end

    assign scl_lvl   = scl_pipe[MSB];
    assign sda_lvl   = sda_pipe[MSB];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twm_cell_array.sv
module twm_cell_array #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we && waddr == AW'(i)) cells[i] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twm_busy_timer.sv
module twm_busy_timer #(
    parameter int CYCLES = 200,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(CYCLES);
        else if (remain != '0)   remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/twm_eeprom_slave.sv
module twm_eeprom_slave
    import twm_pkg::*;
#(
    parameter logic [3:0] DEV_CODE     = 4'b1010,
    parameter int         DEPTH        = 16,
    parameter int         WRITE_CYCLES = 200,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = TWM_BYTE_W;

    logic           scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic           start_det, stop_det;
    twm_state_e     state, nxt;
    twm_state_e     ack_next;
    logic           ack_give, ack_ph, mst_ack;
    logic [3:0]     bit_cnt;
    logic [BW-1:0]  shreg, data_buf, rd_data, rx_byte;
    logic           data_valid;
    logic [AW-1:0]  addr_cnt;
    logic           busy, wr_go;

    twm_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twm_cell_array #(.DEPTH(DEPTH), .WIDTH(BW)) u_cells (
        .clk(clk), .rst_n(rst_n), .we(wr_go), .waddr(addr_cnt),
        .wdata(data_buf), .raddr(addr_cnt), .rdata(rd_data)
    );

    twm_busy_timer #(.CYCLES(WRITE_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy)
    );

    assign rx_byte = {shreg[BW-2:0], sda_lvl};

    // commit: the STOP's own SCL rise samples at most one bit of a new byte
    assign wr_go = stop_det && (state == ST_DATA) && (bit_cnt <= 4'd1) && data_valid;

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_CTRL;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: nxt = state;
                ST_CTRL, ST_ADDR, ST_DATA:
                    if (scl_rise && bit_cnt == 4'd7) nxt = ST_ACK;
                ST_ACK:
                    if (scl_fall && ack_ph) nxt = ack_give ? ack_next : ST_WAIT;
                ST_RD_SEND:
                    if (scl_fall && bit_cnt == 4'd8) nxt = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) nxt = mst_ack ? ST_RD_SEND : ST_WAIT;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            ack_ph     <= 1'b0;
            ack_give   <= 1'b0;
            ack_next   <= ST_IDLE;
            data_buf   <= '0;
            data_valid <= 1'b0;
            addr_cnt   <= '0;
            sda_pull_o <= 1'b0;
            mst_ack    <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt    <= '0;
            ack_ph     <= 1'b0;
            sda_pull_o <= 1'b0;
            data_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_CTRL, ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        shreg <= rx_byte;
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            ack_ph  <= 1'b0;
                            if (state == ST_CTRL) begin
                                ack_give <= (rx_byte[7:4] == DEV_CODE) && !busy;
                                ack_next <= rx_byte[0] ? ST_RD_SEND : ST_ADDR;
                            end else if (state == ST_ADDR) begin
                                addr_cnt   <= rx_byte[AW-1:0];
                                ack_give   <= 1'b1;
                                ack_next   <= ST_DATA;
                                data_valid <= 1'b0;
                            end else begin
                                data_buf   <= rx_byte;
                                data_valid <= 1'b1;
                                ack_give   <= 1'b1;
                                ack_next   <= ST_DATA;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                            // a second bit past a full byte: discard it
                            if (state == ST_DATA && bit_cnt == 4'd1) data_valid <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph     <= 1'b1;
                            sda_pull_o <= ack_give;
                        end else begin
                            ack_ph     <= 1'b0;
                            sda_pull_o <= 1'b0;
                            if (ack_give && ack_next == ST_RD_SEND) begin
                                shreg      <= rd_data;
                                sda_pull_o <= ~rd_data[BW-1];
                                addr_cnt   <= addr_cnt + AW'(1);
                                bit_cnt    <= 4'd1;
                            end
                        end
                    end
                end
                ST_RD_SEND: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_pull_o <= 1'b0;
                            bit_cnt    <= '0;
                        end else begin
                            shreg      <= {shreg[BW-2:0], 1'b0};
                            sda_pull_o <= ~shreg[BW-2];
                            bit_cnt    <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mst_ack <= !sda_lvl;
                    if (scl_fall && mst_ack) begin
                        shreg      <= rd_data;
                        sda_pull_o <= ~rd_data[BW-1];
                        addr_cnt   <= addr_cnt + AW'(1);
                        bit_cnt    <= 4'd1;
                    end
                end
                ST_IDLE, ST_WAIT: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/twm_eeprom_chk.sv
module twm_eeprom_chk
    import twm_pkg::*;
#(
    parameter int  WRITE_CYCLES = 200,
    parameter int  AW           = 4,
    localparam int CW           = $clog2(WRITE_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_pull_o,
    input logic          busy,
    input logic          wr_go,
    input logic [AW-1:0] addr_cnt,
    input twm_state_e    state
);
    logic [CW-1:0] win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         win <= '0;
        else if (wr_go)     win <= CW'(WRITE_CYCLES);
        else if (win != '0) win <= win - CW'(1);
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_pull_o);

    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win != '0) |-> busy);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win == '0) |-> !busy);

    assert_no_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !busy);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> addr_cnt == $past(addr_cnt));
endmodule

bind twm_eeprom_slave twm_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
    .stop_det(stop_det), .sda_pull_o(sda_pull_o), .busy(busy), .wr_go(wr_go),
    .addr_cnt(addr_cnt), .state(state)
);

// File: tb/twm_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twm_eeprom_slave_bench;
    localparam int Q  = 4;
    localparam int WC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_bus;
    int   total = 0;
    int   bad = 0;
    int   glitch = 0;
    bit   done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    twm_eeprom_slave #(.WRITE_CYCLES(WC)) u_twm_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_m = 1'b0;
        wq(); scl = 1'b1;
        wq(); sda_m = 1'b1;
        wq();
    endtask

    task automatic put_bit(input logic b);
        wq(); sda_m = b;
        wq(); scl = 1'b1;
        wq(); wq(); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wq(); sda_m = 1'b1;
        wq(); scl = 1'b1;
        wq(); ack = (sda_bus == 1'b0);
        wq(); scl = 1'b0;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic s1;
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_m = 1'b1;
            wq(); scl = 1'b1;
            wq(); s1 = sda_bus;
            wq(); if (sda_bus != s1) glitch++;
            d[i] = s1;
            scl = 1'b0;
        end
        wq(); sda_m = ~mack;
        wq(); scl = 1'b1;
        wq(); wq(); scl = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d, output bit ok);
        logic k0, k1, k2;
        bus_start();
        send_byte(8'hA0, k0);
        send_byte(a, k1);
        send_byte(d, k2);
        bus_stop();
        ok = k0 & k1 & k2;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic k0, k1;
        bus_start();
        send_byte(8'hA0, k0);
        send_byte(a, k1);
        bus_stop();
    endtask

    task automatic read_one(output logic [7:0] d, output logic ack);
        bus_start();
        send_byte(8'hA1, ack);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic wait_busy();
        repeat (WC + 100) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic k;
        chk(sda_pull == 1'b0, "R1 sda released after reset", int'(sda_pull), 0);
        read_one(d, k);
        chk(k == 1'b1, "R4 ack on read control", int'(k), 1);
        chk(d == 8'h00, "R1 cleared storage at counter 0", d, 8'h00);
    endtask

    task automatic t_write_hold();
        logic [7:0] d; logic k; bit ok;
        write_byte(8'h05, 8'hA7, ok);
        chk(ok, "R4 three acks on byte write", int'(ok), 1);
        wait_busy();
        read_one(d, k);
        chk(d == 8'hA7, "R7 counter stays on written location", d, 8'hA7);
        read_one(d, k);
        chk(d == 8'h00, "R10 counter advanced after read", d, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] d; logic k; bit ok;
        write_byte(8'h02, 8'h5A, ok);
        bus_start();
        send_byte(8'hA0, k);
        bus_stop();
        chk(k == 1'b0, "R6 no ack during write period", int'(k), 0);
        wait_busy();
        read_one(d, k);
        chk(k == 1'b1, "R6 ack after write period", int'(k), 1);
        chk(d == 8'h5A, "R6 byte stored by stop", d, 8'h5A);
    endtask

    task automatic t_upper();
        logic [7:0] d; logic k; bit ok;
        write_byte(8'hF3, 8'h3C, ok);
        wait_busy();
        read_one(d, k);
        chk(d == 8'h3C, "R5 high address bits ignored on write", d, 8'h3C);
        set_ptr(8'h53);
        read_one(d, k);
        chk(d == 8'h3C, "R5 address low nibble loads counter", d, 8'h3C);
    endtask

    task automatic t_devcode();
        logic k;
        bus_start();
        send_byte(8'h90, k);
        bus_stop();
        chk(k == 1'b0, "R3 wrong device code not acked", int'(k), 0);
        bus_start();
        send_byte(8'hAE, k);
        bus_stop();
        chk(k == 1'b1, "R3 dont-care bits set still acked", int'(k), 1);
    endtask

    task automatic t_abort();
        logic [7:0] d; logic k0, k1;
        bus_start();
        send_byte(8'hA0, k0);
        send_byte(8'h02, k1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        read_one(d, k0);
        chk(k0 == 1'b1, "R8 no write period after abort", int'(k0), 1);
        chk(d == 8'h5A, "R8 partial data byte not stored", d, 8'h5A);
    endtask

    task automatic t_extra();
        logic [7:0] d; logic k;
        bus_start();
        send_byte(8'hA0, k);
        send_byte(8'h07, k);
        send_byte(8'h11, k);
        send_byte(8'h22, k);
        bus_stop();
        wait_busy();
        set_ptr(8'h07);
        read_one(d, k);
        chk(d == 8'h22, "R9 last full data byte stored", d, 8'h22);
        bus_start();
        send_byte(8'hA0, k);
        send_byte(8'h07, k);
        send_byte(8'h33, k);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        read_one(d, k);
        chk(k == 1'b1, "R9 mid-byte stop after extra byte: no write period", int'(k), 1);
        chk(d == 8'h22, "R9 mid-byte stop after extra byte: no store", d, 8'h22);
    endtask

    task automatic t_restart();
        logic [7:0] d; logic k;
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'hA1, k);
        get_byte(1'b0, d);
        bus_stop();
        chk(k == 1'b1, "R2 repeated start restarts decoding", int'(k), 1);
        chk(d == 8'h00, "R2 read after restart at counter 8", d, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] d0, d1; logic k; bit ok;
        write_byte(8'h00, 8'h81, ok);
        wait_busy();
        write_byte(8'h0F, 8'hC5, ok);
        wait_busy();
        set_ptr(8'h0F);
        bus_start();
        send_byte(8'hA1, k);
        get_byte(1'b1, d0);
        get_byte(1'b0, d1);
        bus_stop();
        chk(d0 == 8'hC5, "R10 first byte of sequential read", d0, 8'hC5);
        chk(d1 == 8'h81, "R10 counter wraps 15 to 0", d1, 8'h81);
        chk(sda_pull == 1'b0, "R10 released after master nack", int'(sda_pull), 0);
        chk(glitch == 0, "R11 data stable while SCL high", glitch, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_hold();
        t_busy();
        t_upper();
        t_devcode();
        t_abort();
        t_extra();
        t_restart();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule